// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs a processor's interrupt entry as a fixed series of word transfers. It waits for an instruction boundary. If an interrupt request is pending at that boundary, it latches the winning 4-bit level. From that level it forms two pointer addresses: an even linkage pointer and the odd service pointer just above it. It reads both pointer words to learn where the old context is to be saved and where the new context lives.

The sequencer saves the running status word, mask and instruction counter to the linkage area. It then clears the status register with an all-zero status I/O write. Next it reads the new mask, which is loaded at the same moment as the interrupt enable is cleared. It reads the new status word and screens its address-state field. It writes the screened status word out through the status I/O command. Last, it reads the new instruction counter and pulses `done` so that fetch restarts from that address.

A non-zero address-state field is illegal when no memory management unit is fitted. In that case the field is forced to zero, the address-state fault bit is raised, and interrupt level 1 is flagged pending. All transfers go through a single word-wide valid/ready port. The port is a memory access when `mem_io` is low and an I/O command when it is high.

Top module: `irq_entry_seq`

## Requirements
- R1: An entry starts only when the sequencer is idle and `insn_done` and `irq_req` are both high at a rising edge. In every other case `mem_valid` stays low.
- R2: The level on `irq_level` at the starting edge is held on `entry_level` for the whole entry and after it.
- R3: For level n, the first transfer is a memory read of 0x20+2n (the linkage pointer). The second is a memory read of 0x21+2n (the service pointer). Their read data become the link base and the service base.
- R4: The next three transfers are memory writes. The current status word goes to link base+0, the current mask to link base+1 and the current instruction counter to link base+2, in that order.
- R5: The sixth transfer is an I/O write (`mem_io`=1) to `SW_IO_ADDR` (default 0x2000) with data 0.
- R6: The seventh transfer reads the new mask from service base+0. In the cycle after its handshake, `mask_we` and `ie_clr` pulse together and `new_mask` carries the word read.
- R7: The eighth transfer reads the new status word from service base+1. If its address-state field (bits [3:0]) is non-zero and `HAS_MMU`=0, the field is cleared. In that case, one cycle after the handshake, `fault_set` bit 11 and `pend_set` bit 1 pulse together.
- R8: The ninth transfer is an I/O write to `SW_IO_ADDR` that carries the screened status word.
- R9: While `mem_valid` is high and `mem_ready` is low, the request holds its address, data and direction unchanged.
- R10: The tenth and last transfer reads the new instruction counter from service base+2. One cycle after its handshake, `done` pulses for exactly one cycle with that word on `new_ic`, and the sequencer returns to idle.
- R11: `insn_done` and `irq_req` arriving while an entry is in progress are ignored. The entry still makes exactly ten transfers and keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_done | input | 1 | Current instruction has completed |
| irq_req | input | 1 | An unmasked interrupt is pending |
| irq_level | input | LW | Winning interrupt level |
| cur_sw | input | DW | Running status word, held by the datapath during entry |
| cur_mask | input | DW | Running interrupt mask |
| cur_ic | input | DW | Running instruction counter |
| mem_valid | output | 1 | Transfer request |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_io | output | 1 | 1 = I/O command, 0 = memory |
| mem_addr | output | AW | Transfer address |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Transfer accepted at this edge |
| mem_rdata | input | DW | Read data, valid with `mem_ready` |
| busy | output | 1 | Entry in progress |
| entry_level | output | LW | Level being serviced |
| mask_we | output | 1 | Load `new_mask` into the mask register |
| new_mask | output | DW | New mask word |
| ie_clr | output | 1 | Clear the interrupt enable |
| fault_set | output | DW | One-cycle fault bits to set |
| pend_set | output | 2**LW | One-cycle pending-level bits to set |
| done | output | 1 | Entry complete; restart fetch |
| new_ic | output | DW | New instruction counter |

## Verification
The address-state fault and the level-1 pending flag must appear in the same cycle, and neither may appear without the other. The bench provokes this by giving odd levels a service-area status word with a non-zero address-state field, and giving even levels a clean one. A per-cycle monitor flags any cycle in which `fault_set` bit 11 and `pend_set` bit 1 differ. The per-entry counts must equal one for odd levels and zero for even ones, and the ninth transfer must carry the cleared word. The same monitor judges the other coincident pair, the mask load and the interrupt-enable clear, in the same way.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_LP,
      ST_RD_SP,
      ST_SV_SW,
      ST_SV_MK,
      ST_SV_IC,
      ST_IO_ZERO,
      ST_RD_NMK,
      ST_RD_NSW,
      ST_IO_NSW,
      ST_RD_NIC
   } entry_state_e;

   // word offsets inside the linkage (save) area
   localparam int LNK_OFF_SW = 0;
   localparam int LNK_OFF_MK = 1;
   localparam int LNK_OFF_IC = 2;
   // word offsets inside the service (new context) area
   localparam int SVC_OFF_MK = 0;
   localparam int SVC_OFF_SW = 1;
   localparam int SVC_OFF_IC = 2;

endpackage

// File: rtl/irq_ptr_gen.sv
module irq_ptr_gen #(
   parameter int          AW       = 16,
   parameter int          LW       = 4,
   parameter logic [15:0] PTR_BASE = 16'h0020
) (
   input  logic [LW-1:0] level,
   output logic [AW-1:0] link_ptr,
   output logic [AW-1:0] svc_ptr
);
   localparam logic [AW-1:0] BASE = AW'(PTR_BASE);

   initial begin
      AST_PTR_ALIGN: assert (PTR_BASE[0] == 1'b0)
         else $error("pointer base must be even"); // R3
      AST_PTR_FIT: assert (AW > LW + 1)
         else $error("address too narrow for pointer table"); // R3
   end

   always_comb begin
      link_ptr = BASE + AW'({level, 1'b0});
      svc_ptr  = link_ptr + AW'(1);
   end
endmodule

// File: rtl/irq_as_guard.sv
module irq_as_guard #(
   parameter int DW      = 16,
   parameter int AS_LSB  = 0,
   parameter int AS_W    = 4,
   parameter bit HAS_MMU = 1'b0
) (
   input  logic [DW-1:0] sw_in,
   output logic [DW-1:0] sw_out,
   output logic          as_err
);
   localparam logic [DW-1:0] AS_MASK = {{(DW-AS_W){1'b0}}, {AS_W{1'b1}}} << AS_LSB;

   initial begin
      AST_AS_FIELD_FITS: assert (AS_LSB + AS_W <= DW)
         else $error("address-state field outside status word"); // R7
   end

   generate
      if (HAS_MMU) begin : g_mmu
         always_comb begin
            sw_out = sw_in;
            as_err = 1'b0;
         end
      end else begin : g_flat
         always_comb begin
            as_err = |(sw_in & AS_MASK);
            sw_out = sw_in & ~AS_MASK;
         end
      end
   endgenerate
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
   import irq_entry_pkg::*;
#(
   parameter int          DW           = 16,
   parameter int          AW           = 16,
   parameter int          LW           = 4,
   parameter logic [15:0] PTR_BASE     = 16'h0020,
   parameter logic [15:0] SW_IO_ADDR   = 16'h2000,
   parameter int          AS_LSB       = 0,
   parameter int          AS_W         = 4,
   parameter bit          HAS_MMU      = 1'b0,
   parameter int          FAULT_AS_BIT = 11,
   parameter int          AS_IRQ_LVL   = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 insn_done,
   input  logic                 irq_req,
   input  logic [LW-1:0]        irq_level,
   input  logic [DW-1:0]        cur_sw,
   input  logic [DW-1:0]        cur_mask,
   input  logic [DW-1:0]        cur_ic,
   output logic                 mem_valid,
   output logic                 mem_write,
   output logic                 mem_io,
   output logic [AW-1:0]        mem_addr,
   output logic [DW-1:0]        mem_wdata,
   input  logic                 mem_ready,
   input  logic [DW-1:0]        mem_rdata,
   output logic                 busy,
   output logic [LW-1:0]        entry_level,
   output logic                 mask_we,
   output logic [DW-1:0]        new_mask,
   output logic                 ie_clr,
   output logic [DW-1:0]        fault_set,
   output logic [(1<<LW)-1:0]   pend_set,
   output logic                 done,
   output logic [DW-1:0]        new_ic
);
   localparam int            NLVL    = 1 << LW;
   localparam logic [AW-1:0] IO_SW_A = AW'(SW_IO_ADDR);

   initial begin
      AST_FAULT_BIT_FITS: assert (FAULT_AS_BIT < DW)
         else $error("fault bit outside fault word"); // R7
      AST_IRQ_LVL_FITS: assert (AS_IRQ_LVL < NLVL)
         else $error("fault level outside level range"); // R7
   end

   entry_state_e  state, state_nx;
   logic [AW-1:0] link_ptr, svc_ptr;
   logic [AW-1:0] link_base, svc_base;
   logic [DW-1:0] nsw_q, nsw_fixed;
   logic          as_err;

   irq_ptr_gen #(.AW(AW), .LW(LW), .PTR_BASE(PTR_BASE)) u_ptr (
      .level    (entry_level),
      .link_ptr (link_ptr),
      .svc_ptr  (svc_ptr)
   );

   irq_as_guard #(.DW(DW), .AS_LSB(AS_LSB), .AS_W(AS_W), .HAS_MMU(HAS_MMU)) u_guard (
      .sw_in  (mem_rdata),
      .sw_out (nsw_fixed),
      .as_err (as_err)
   );

   assign busy      = (state != ST_IDLE);
   assign mem_valid = busy;

   // one request per state; fields stay put until the handshake
   always_comb begin
      mem_write = 1'b0;
      mem_io    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state)
         ST_RD_LP:   mem_addr = link_ptr;
         ST_RD_SP:   mem_addr = svc_ptr;
         ST_SV_SW: begin
            mem_write = 1'b1;
            mem_addr  = link_base + AW'(LNK_OFF_SW);
            mem_wdata = cur_sw;
         end
         ST_SV_MK: begin
            mem_write = 1'b1;
            mem_addr  = link_base + AW'(LNK_OFF_MK);
            mem_wdata = cur_mask;
         end
         ST_SV_IC: begin
            mem_write = 1'b1;
            mem_addr  = link_base + AW'(LNK_OFF_IC);
            mem_wdata = cur_ic;
         end
         ST_IO_ZERO: begin
            mem_write = 1'b1;
            mem_io    = 1'b1;
            mem_addr  = IO_SW_A;
         end
         ST_RD_NMK:  mem_addr = svc_base + AW'(SVC_OFF_MK);
         ST_RD_NSW:  mem_addr = svc_base + AW'(SVC_OFF_SW);
         ST_IO_NSW: begin
            mem_write = 1'b1;
            mem_io    = 1'b1;
            mem_addr  = IO_SW_A;
            mem_wdata = nsw_q;
         end
         ST_RD_NIC:  mem_addr = svc_base + AW'(SVC_OFF_IC);
         default: ;
      endcase
   end

   always_comb begin
      unique case (state)
         ST_RD_LP:   state_nx = ST_RD_SP;
         ST_RD_SP:   state_nx = ST_SV_SW;
         ST_SV_SW:   state_nx = ST_SV_MK;
         ST_SV_MK:   state_nx = ST_SV_IC;
         ST_SV_IC:   state_nx = ST_IO_ZERO;
         ST_IO_ZERO: state_nx = ST_RD_NMK;
         ST_RD_NMK:  state_nx = ST_RD_NSW;
         ST_RD_NSW:  state_nx = ST_IO_NSW;
         ST_IO_NSW:  state_nx = ST_RD_NIC;
         default:    state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         entry_level <= '0;
         link_base   <= '0;
         svc_base    <= '0;
         nsw_q       <= '0;
         new_mask    <= '0;
         new_ic      <= '0;
         mask_we     <= 1'b0;
         ie_clr      <= 1'b0;
         fault_set   <= '0;
         pend_set    <= '0;
         done        <= 1'b0;
      end else begin
         mask_we   <= 1'b0;
         ie_clr    <= 1'b0;
         fault_set <= '0;
         pend_set  <= '0;
         done      <= 1'b0;
         if (state == ST_IDLE) begin
            if (insn_done && irq_req) begin
               entry_level <= irq_level;
               state       <= ST_RD_LP;
            end
         end else if (mem_ready) begin
            state <= state_nx;
            unique case (state)
               ST_RD_LP:  link_base <= AW'(mem_rdata);
               ST_RD_SP:  svc_base  <= AW'(mem_rdata);
               ST_RD_NMK: begin
                  new_mask <= mem_rdata;
                  mask_we  <= 1'b1;
                  ie_clr   <= 1'b1;
               end
               ST_RD_NSW: begin
                  nsw_q <= nsw_fixed;
                  if (as_err) begin
                     fault_set[FAULT_AS_BIT] <= 1'b1;
                     pend_set[AS_IRQ_LVL]    <= 1'b1;
                  end
               end
               ST_RD_NIC: begin
                  new_ic <= mem_rdata;
                  done   <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   AST_START_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_valid) |-> $past(insn_done && irq_req)); // R1

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
         && $stable(mem_wdata) && $stable(mem_write) && $stable(mem_io))); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !mem_valid)); // R10

   generate
      if (!HAS_MMU) begin : g_as_chk
         AST_AS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_valid && mem_io && mem_write) |-> (mem_wdata[AS_LSB +: AS_W] == '0)); // R7
      end
   endgenerate
endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        insn_done = 1'b0, irq_req = 1'b0;
   logic [3:0]  irq_level = '0;
   logic [15:0] cur_sw = '0, cur_mask = '0, cur_ic = '0;
   logic        mem_valid, mem_write, mem_io;
   logic [15:0] mem_addr, mem_wdata;
   logic        mem_ready = 1'b0;
   logic [15:0] mem_rdata = '0;
   logic        busy, mask_we, ie_clr, done;
   logic [3:0]  entry_level;
   logic [15:0] new_mask, fault_set, new_ic;
   logic [15:0] pend_set;

   irq_entry_seq uut (
      .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .irq_req(irq_req),
      .irq_level(irq_level), .cur_sw(cur_sw), .cur_mask(cur_mask), .cur_ic(cur_ic),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_io(mem_io),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
      .mem_rdata(mem_rdata), .busy(busy), .entry_level(entry_level),
      .mask_we(mask_we), .new_mask(new_mask), .ie_clr(ie_clr),
      .fault_set(fault_set), .pend_set(pend_set), .done(done), .new_ic(new_ic)
   );

   always #4 clk = ~clk;

   int n_vec = 0, n_bad = 0;
   logic [15:0] mem [0:255];

   // transfer log and pulse monitor, filled by the responder
   logic [15:0] t_addr [0:15];
   logic [15:0] t_data [0:15];
   bit          t_wr [0:15];
   bit          t_io [0:15];
   int n_txn = 0, wait_cnt = 0, hold_err = 0, pair_err = 0, stray_err = 0;
   int n_mask = 0, n_ie = 0, n_fault = 0, n_pend = 0, n_done = 0, done_txn = 0;
   logic [15:0] cap_mask = '0, cap_ic = '0, hold_addr = '0, hold_data = '0;
   bit pend_seen = 1'b0;

   always @(negedge clk) begin
      if (mem_ready) begin
         mem_ready = 1'b0;
         wait_cnt  = (n_txn * 7 + 1) % 3;
      end else if (mem_valid) begin
         if (!pend_seen) begin
            pend_seen = 1'b1;
            hold_addr = mem_addr;
            hold_data = mem_wdata;
         end
         if (wait_cnt == 0) begin
            if (mem_addr != hold_addr || mem_wdata != hold_data) hold_err++;
            pend_seen = 1'b0;
            if (n_txn < 16) begin
               t_addr[n_txn] = mem_addr;
               t_data[n_txn] = mem_wdata;
               t_wr[n_txn]   = mem_write;
               t_io[n_txn]   = mem_io;
            end
            n_txn++;
            if (mem_write && !mem_io) mem[mem_addr[7:0]] = mem_wdata;
            mem_rdata = mem[mem_addr[7:0]];
            mem_ready = 1'b1;
         end else begin
            wait_cnt--;
         end
      end
      if (mask_we != ie_clr) pair_err++;
      if (fault_set[11] != pend_set[1]) pair_err++;
      if ((fault_set & ~16'h0800) != 0 || (pend_set & ~16'h0002) != 0) stray_err++;
      if (mask_we) begin n_mask++; cap_mask = new_mask; end
      if (ie_clr) n_ie++;
      if (fault_set[11]) n_fault++;
      if (pend_set[1]) n_pend++;
      if (done) begin n_done++; cap_ic = new_ic; done_txn = n_txn; end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog run did not end actual=0 expected=1");
      finish_run();
   end

   function automatic void expect_txn(input int k, input int n,
         output logic [15:0] a, output bit w, output bit io,
         output logic [15:0] d, output string r);
      logic [15:0] lb, sb;
      lb = 16'h0080 + 16'(4 * n);
      sb = 16'h00C0 + 16'(4 * n);
      w = 1'b0; io = 1'b0; d = '0;
      case (k)
         0: begin a = 16'h0020 + 16'(2 * n); r = "R3"; end
         1: begin a = 16'h0021 + 16'(2 * n); r = "R3"; end
         2: begin a = lb;      w = 1; d = 16'h3000 + 16'(n); r = "R4"; end
         3: begin a = lb + 1;  w = 1; d = 16'h4400 + 16'(n); r = "R4"; end
         4: begin a = lb + 2;  w = 1; d = 16'h6000 + 16'(n); r = "R4"; end
         5: begin a = 16'h2000; w = 1; io = 1; d = 16'h0000; r = "R5"; end
         6: begin a = sb;     r = "R6"; end
         7: begin a = sb + 1; r = "R7"; end
         8: begin a = 16'h2000; w = 1; io = 1; d = 16'h5A00 | 16'(n << 4); r = "R8"; end
         default: begin a = sb + 2; r = "R10"; end
      endcase
   endfunction

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      for (int n = 0; n < 16; n++) begin
         mem[8'h20 + 2*n] = 16'h0080 + 16'(4 * n);
         mem[8'h21 + 2*n] = 16'h00C0 + 16'(4 * n);
         mem[8'hC0 + 4*n] = 16'h1100 + 16'(n);
         mem[8'hC1 + 4*n] = 16'h5A00 | 16'(n << 4) | ((n % 2 == 1) ? 16'(n) : 16'h0);
         mem[8'hC2 + 4*n] = 16'h7000 + 16'(n);
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!mem_valid && !busy && !done && !mask_we, "R1", "reset idle", int'(mem_valid), 0);

      // R1: request without boundary, boundary without request
      irq_req = 1'b1; irq_level = 4'd3;
      repeat (10) @(negedge clk);
      check(n_txn == 0 && !mem_valid, "R1", "request without insn_done", n_txn, 0);
      irq_req = 1'b0; insn_done = 1'b1;
      repeat (10) @(negedge clk);
      check(n_txn == 0 && !mem_valid, "R1", "insn_done without request", n_txn, 0);
      insn_done = 1'b0;

      for (int n = 0; n < 16; n++) begin
         logic [15:0] ea, ed;
         bit ew, eio;
         string er;
         int guard;
         @(posedge clk);
         n_txn = 0; n_mask = 0; n_ie = 0; n_fault = 0; n_pend = 0;
         n_done = 0; done_txn = 0;
         @(negedge clk);
         cur_sw = 16'h3000 + 16'(n); cur_mask = 16'h4400 + 16'(n); cur_ic = 16'h6000 + 16'(n);
         irq_level = 4'(n); irq_req = 1'b1; insn_done = 1'b1;
         @(negedge clk);
         insn_done = 1'b0; irq_req = 1'b0;
         repeat (3) @(negedge clk);
         // R11: a second boundary with a different level while busy
         irq_level = 4'((n + 5) % 16); irq_req = 1'b1; insn_done = 1'b1;
         @(negedge clk);
         insn_done = 1'b0; irq_req = 1'b0;
         guard = 0;
         while (n_done == 0 && guard < 400) begin @(negedge clk); guard++; end
         repeat (6) @(negedge clk);
         for (int k = 0; k < 10; k++) begin
            expect_txn(k, n, ea, ew, eio, ed, er);
            check(t_addr[k] == ea && t_wr[k] == ew && t_io[k] == eio
                  && (!ew || t_data[k] == ed), er,
                  $sformatf("level %0d transfer %0d addr/data", n, k),
                  int'({t_addr[k], t_data[k]}), int'({ea, ed}));
         end
         check(n_txn == 10 && !mem_valid, "R11", $sformatf("level %0d transfer count", n), n_txn, 10);
         check(entry_level == 4'(n), "R2", $sformatf("level %0d held", n), int'(entry_level), n);
         check(n_mask == 1 && n_ie == 1 && cap_mask == 16'h1100 + 16'(n), "R6",
               $sformatf("level %0d mask load", n), int'(cap_mask), 16'h1100 + n);
         check(n_fault == n % 2 && n_pend == n % 2, "R7",
               $sformatf("level %0d as fault count", n), n_fault, n % 2);
         check(n_done == 1 && done_txn == 10 && cap_ic == 16'h7000 + 16'(n), "R10",
               $sformatf("level %0d done and new ic", n), int'(cap_ic), 16'h7000 + n);
      end
      check(hold_err == 0, "R9", "request held while stalled", hold_err, 0);
      check(pair_err == 0, "R7", "coincident pulse pairs", pair_err, 0);
      check(stray_err == 0, "R7", "stray fault or pending bits", stray_err, 0);
      finish_run();
   end
endmodule